// File: doc/BRIEF.md
# Stack limit guard

This block watches the stack pointer against a programmable lower bound. A processor core tells it when the stack pointer has changed and when an instruction has finished. A check is made only when something has touched the stack pointer or the bound since the last check. At the next end-of-instruction strobe the block compares the pointer with the effective bound and reports one of three results. The pointer may be at or above the bound, in which case nothing is reported. It may be slightly below the bound, which requests a yellow trap to be taken after the instruction. It may be more than a guard distance below the bound, which raises an immediate red abort and tells the core to reload the stack pointer with a fixed safe value.

The bound register keeps only its upper byte, so the bound moves in steps of 256 bytes. A stored bound of zero counts as 256. Each yellow or red outcome latches a flag in a small error word. While either flag is latched, the block reports nothing further and keeps its pending check. Software clears the flags by writing zero to the error word.

Top module: `stack_guard`

## Requirements
- R1: A write to the bound register stores only bits 15:8 of the written data, and the low byte is stored as zero. The stored value is visible on `lim_rdata` from the cycle after the write.
- R2: A stored bound of zero is compared as if it were 16'h0100.
- R3: After reset no check is pending, so an end-of-instruction strobe raises neither trap output, whatever the stack pointer holds.
- R4: A check is armed by `sp_chg` or `lim_wr`. An evaluation clears the armed check, so a further end-of-instruction strobe with no new change reports nothing.
- R5: When an armed check finds the pointer at or above the effective bound, neither trap output rises and the error word stays zero.
- R6: When the pointer is below the effective bound but pointer+32 is not below it, `yel_trap` is high for the cycle after the strobe and bit 3 (value 16'h0008) is set in `err_bits`.
- R7: When pointer+32 (17-bit sum) is below the effective bound, `red_abort` and `sp_force_vld` are high for the cycle after the strobe and `yel_trap` stays low. `sp_force_val` reads 4, and `err_bits` holds bits 3 and 2 together (16'h000C).
- R8: While `err_bits` is nonzero, an end-of-instruction strobe raises no trap output and the armed check is kept. After the flags are cleared, the next strobe evaluates it.
- R9: A write to the error word loads bits 3 and 2 from the data and clears every other bit, so a write of zero clears both flags. Reset also clears the error word.
- R10: `yel_trap`, `red_abort` and `sp_force_vld` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_wr | input | 1 | Write strobe for the bound register |
| lim_wdata | input | 16 | Data to write to the bound register |
| lim_rdata | output | 16 | Stored bound |
| sp_chg | input | 1 | The stack pointer changed in this cycle |
| sp | input | 16 | Current stack pointer |
| instr_end | input | 1 | Instruction completed |
| err_wr | input | 1 | Write strobe for the error word |
| err_wdata | input | 16 | Data to write to the error word |
| err_bits | output | 16 | Error word: bit 3 yellow, bit 2 red |
| yel_trap | output | 1 | Request for a yellow trap after the instruction |
| red_abort | output | 1 | Request for an immediate red abort |
| sp_force_vld | output | 1 | The core must load `sp_force_val` into the stack pointer |
| sp_force_val | output | 16 | Forced stack pointer value |

## Verification
The bench aims at the exact boundaries. It checks a pointer equal to the bound, and a pointer exactly 32 below it, which must be yellow and not red. A design that used the wrong comparison would trap on the first case or abort on the second. A stored bound of zero must act as 256: a design that compared against zero would never trap. A write with a nonzero low byte must lose that byte, or the masked case would turn red. The bench also checks the armed check at three points: after reset, across a second strobe, and while the flags block reporting. A design that armed on reset would trap a cold machine. One that did not clear the check would trap again. One that dropped the check while blocked would miss the violation once the flags are cleared.

// File: rtl/stack_guard.sv
module stack_guard #(
  parameter int W         = 16,
  parameter int LIM_LSB   = 8,
  parameter int GUARD     = 32,
  parameter int FORCED_SP = 4,
  parameter int EMPTY_LIM = 256,
  parameter int YEL_BIT   = 3,
  parameter int RED_BIT   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lim_wr,
  input  logic [W-1:0] lim_wdata,
  output logic [W-1:0] lim_rdata,
  input  logic         sp_chg,
  input  logic [W-1:0] sp,
  input  logic         instr_end,
  input  logic         err_wr,
  input  logic [W-1:0] err_wdata,
  output logic [W-1:0] err_bits,
  output logic         yel_trap,
  output logic         red_abort,
  output logic         sp_force_vld,
  output logic [W-1:0] sp_force_val
);

  localparam logic [W-1:0] KEEP = {{(W-LIM_LSB){1'b1}}, {LIM_LSB{1'b0}}};

  logic [W-1:0] lim_q;
  logic         armed_q, ey_q, er_q, yel_q, red_q;

  wire [W-1:0] lim_eff = (lim_q == '0) ? W'(EMPTY_LIM) : lim_q;
  wire [W:0]   sp_pad  = {1'b0, sp} + (W+1)'(GUARD);
  wire         below   = sp < lim_eff;
  wire         deep    = sp_pad < {1'b0, lim_eff};
  wire         blocked = ey_q | er_q;
  wire         fire    = instr_end & (armed_q | sp_chg | lim_wr) & ~blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q   <= '0;
      armed_q <= 1'b0;
      ey_q    <= 1'b0;
      er_q    <= 1'b0;
      yel_q   <= 1'b0;
      red_q   <= 1'b0;
    end else begin
      if (lim_wr) lim_q <= lim_wdata & KEEP;
      if (fire) armed_q <= 1'b0;
      else if (sp_chg | lim_wr) armed_q <= 1'b1;
      yel_q <= fire & below & ~deep;
      red_q <= fire & deep;
      ey_q  <= (err_wr ? err_wdata[YEL_BIT] : ey_q) | (fire & below);
      er_q  <= (err_wr ? err_wdata[RED_BIT] : er_q) | (fire & deep);
    end
  end

  always_comb begin
    err_bits          = '0;
    err_bits[YEL_BIT] = ey_q;
    err_bits[RED_BIT] = er_q;
  end

  assign lim_rdata    = lim_q;
  assign yel_trap     = yel_q;
  assign red_abort    = red_q;
  assign sp_force_vld = red_q;
  assign sp_force_val = W'(FORCED_SP);

endmodule

module stack_guard_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         instr_end,
  input logic         err_wr,
  input logic [W-1:0] err_bits,
  input logic [W-1:0] lim_rdata,
  input logic         yel_trap,
  input logic         red_abort,
  input logic         sp_force_vld
);
  always_comb if (rst_n) assert_lim_low_zero_R1: assert (lim_rdata[7:0] == 8'h00);

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(yel_trap && red_abort));
  assert_red_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    red_abort |-> (sp_force_vld && err_bits[3] && err_bits[2]));
  assert_yel_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    yel_trap |-> err_bits[3]);
  assert_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (yel_trap || red_abort) |-> $past(instr_end));
  assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_bits != '0 && !err_wr) |-> !(yel_trap || red_abort));
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (yel_trap || red_abort) |=> !(yel_trap || red_abort));
endmodule

bind stack_guard stack_guard_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .err_wr(err_wr),
  .err_bits(err_bits), .lim_rdata(lim_rdata), .yel_trap(yel_trap),
  .red_abort(red_abort), .sp_force_vld(sp_force_vld)
);

// File: tb/stack_guard_test.sv
module stack_guard_test;
  logic clk = 0, rst_n = 0;
  logic lim_wr = 0, sp_chg = 0, instr_end = 0, err_wr = 0;
  logic [15:0] lim_wdata = 0, sp = 0, err_wdata = 0;
  logic [15:0] lim_rdata, err_bits, sp_force_val;
  logic yel_trap, red_abort, sp_force_vld;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stack_guard uut (.*);

  // {bound, sp, yellow, red, error word}
  localparam logic [49:0] VEC [11] = '{
    {16'h0200, 16'h0300, 1'b0, 1'b0, 16'h0000},
    {16'h0200, 16'h0200, 1'b0, 1'b0, 16'h0000},
    {16'h0200, 16'h01FE, 1'b1, 1'b0, 16'h0008},
    {16'h0200, 16'h01E0, 1'b1, 1'b0, 16'h0008},
    {16'h0200, 16'h01DF, 1'b0, 1'b1, 16'h000C},
    {16'h0000, 16'h0100, 1'b0, 1'b0, 16'h0000},
    {16'h0000, 16'h00FF, 1'b1, 1'b0, 16'h0008},
    {16'h0000, 16'h00DF, 1'b0, 1'b1, 16'h000C},
    {16'h12FF, 16'h11FF, 1'b1, 1'b0, 16'h0008},
    {16'hFF00, 16'hFFFE, 1'b0, 1'b0, 16'h0000},
    {16'hFF00, 16'h0000, 1'b0, 1'b1, 16'h000C}
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_err();
    err_wr = 1; err_wdata = 0; tick(); err_wr = 0;
  endtask

  task automatic strobe_end();
    instr_end = 1; tick(); instr_end = 0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst_n = 1;
    chk("R9 reset err", err_bits, 16'h0000);
    chk("R1 reset bound", lim_rdata, 16'h0000);
    chk("R3 reset outs", {13'b0, yel_trap, red_abort, sp_force_vld}, 16'h0);

    sp = 16'h0000;
    strobe_end();
    chk("R3 cold not armed", {14'b0, yel_trap, red_abort}, 16'h0);
    chk("R3 cold err", err_bits, 16'h0000);

    sp = 16'h00F0; sp_chg = 1; tick(); sp_chg = 0;
    strobe_end();
    chk("R4 armed by sp_chg", {14'b0, yel_trap, red_abort}, 16'h2);
    tick();
    chk("R10 pulse ends", {14'b0, yel_trap, red_abort}, 16'h0);
    chk("R6 flag held", err_bits, 16'h0008);

    lim_wr = 1; lim_wdata = 16'h0400; tick(); lim_wr = 0;
    strobe_end();
    chk("R8 blocked", {14'b0, yel_trap, red_abort}, 16'h0);
    clear_err();
    chk("R9 write zero clears", err_bits, 16'h0000);
    strobe_end();
    chk("R8 kept armed red", {14'b0, yel_trap, red_abort}, 16'h1);
    chk("R7 force value", sp_force_val, 16'h0004);
    clear_err();
    strobe_end();
    chk("R4 disarmed", {14'b0, yel_trap, red_abort}, 16'h0);

    err_wr = 1; err_wdata = 16'hFFFF; tick(); err_wr = 0;
    chk("R9 write loads flags", err_bits, 16'h000C);
    clear_err();

    foreach (VEC[i]) begin
      logic [15:0] vl, vs, ve;
      logic vy, vr;
      {vl, vs, vy, vr, ve} = VEC[i];
      clear_err();
      lim_wr = 1; lim_wdata = vl; sp = vs; sp_chg = 1; tick();
      lim_wr = 0; sp_chg = 0;
      chk($sformatf("R1 bound v%0d", i), lim_rdata, vl & 16'hFF00);
      strobe_end();
      chk($sformatf("R5 R6 R7 outs v%0d", i),
          {13'b0, yel_trap, red_abort, sp_force_vld}, {13'b0, vy, vr, vr});
      chk($sformatf("R2 R6 R7 err v%0d", i), err_bits, ve);
      tick();
      chk($sformatf("R10 pulse v%0d", i),
          {13'b0, yel_trap, red_abort, sp_force_vld}, 16'h0);
    end

    rst_n = 0; tick(); rst_n = 1;
    chk("R9 reset clears err", err_bits, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule